// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received frame is kept, based only on its 48-bit destination address. It holds ten station address slots, each six bytes, in a byte-wide register window that software reaches through a page number and a byte offset. The slots are packed back to back, so a single slot may begin on one page and end on the next. A destination presented with a one-cycle valid pulse is compared against the active slots. The match result is combined with four mode bits and a multicast hash hit from outside. The block returns a registered verdict together with classification flags.

The destination byte that goes out on the wire first sits in bits 7:0 of the address input. Multicast is decided from bit 0 of that byte. The hash hit comes from a separate CRC unit and is sampled in the same cycle as the destination.

Top module: `rxaddr_filter`

## Requirements
- R1: The store holds 60 bytes. Page P in 0x50..0x57 with offset O in 0x8..0xF selects linear index L = (P-0x50)*8 + (O-8). Slot S = L/6 and byte K = L%6, so slot 1 spans page 0x50 offsets 0xE..0xF and page 0x51 offsets 0x8..0xB. A write stores the data there. The read data shows that byte in the same cycle. Byte K of a slot is compared with dst_addr[8K+7:8K].
- R2: A write outside the window is ignored, and a read there returns 0. Outside the window means a page outside 0x50..0x57, an offset below 0x8, or L of 60 or more (page 0x57, offsets 0xC..0xF).
- R3: res_valid is high in exactly the cycle after dst_valid was high, and low otherwise. The flags come with it.
- R4: res_match is 1 when the destination equals slot 0, whatever the mode. It is also 1 when mode_bits[0] is 1 and the destination equals any of slots 1..9.
- R5: A destination with dst_addr[0]=1 is multicast, and then res_phys=0. Otherwise res_phys=1. An all-ones destination sets res_bcast=1 and is also classed as multicast.
- R6: A multicast destination that is not broadcast is accepted when mode_bits[1] (all-multicast) is 1 or hash_hit is 1.
- R7: A broadcast destination is accepted unless mode_bits[3] (broadcast reject) is 1. The reject bit does not override a slot match.
- R8: A physical destination that matches no slot is accepted only when mode_bits[2] (promiscuous) is 1.
- R9: A slot match always gives res_accept=1.
- R10: After reset every slot byte reads 0 and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_page | input | 8 | Register page select |
| cfg_off | input | 4 | Byte offset within the page |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the selected page and offset |
| dst_valid | input | 1 | Destination address valid pulse |
| dst_addr | input | 48 | Destination address, first wire byte in bits 7:0 |
| mode_bits | input | 4 | 0 slot enable, 1 all-multicast, 2 promiscuous, 3 broadcast reject |
| hash_hit | input | 1 | External multicast hash hit |
| res_valid | output | 1 | Verdict valid |
| res_accept | output | 1 | Frame accepted |
| res_phys | output | 1 | 1 physical, 0 multicast |
| res_bcast | output | 1 | Broadcast destination |
| res_match | output | 1 | Destination equals an active slot |

## Verification
The bench programs slots that cross a page boundary, including the last slot, which ends at offset 0xB of the last page. A design with a wrong index map would then either miss these slots or match on bytes from the neighbouring slot. It writes at the edges of the window and then reads back all sixty bytes, which catches decodes that alias stray writes into the store. It checks that slot 0 matches with the slot-enable bit clear while slot 1 does not. It also checks broadcast under the reject bit, with all-multicast set as well. A design that treated broadcast as plain multicast, or that gated slot 0 by the enable bit, would report the wrong verdict here. Back-to-back destinations test that each verdict lands exactly one cycle later.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
   localparam int MODE_W       = 4;
   localparam int MODE_IA_EN   = 0;
   localparam int MODE_ALLMC   = 1;
   localparam int MODE_PROMISC = 2;
   localparam int MODE_BC_REJ  = 3;

   typedef struct packed {
      logic accept;
      logic phys;
      logic bcast;
      logic match;
   } rxaf_verdict_t;
endpackage

// File: rtl/rxaf_store.sv
module rxaf_store #(
   parameter int NUM_SLOTS  = 10,
   parameter int ADDR_BYTES = 6,
   parameter int WIN_BYTES  = 8,
   parameter int PAGE_W     = 8,
   parameter int OFF_W      = 4,
   parameter int BASE_PAGE  = 'h50
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [PAGE_W-1:0]                 cfg_page,
   input  logic [OFF_W-1:0]                  cfg_off,
   input  logic [7:0]                        cfg_wdata,
   output logic [7:0]                        cfg_rdata,
   output logic [NUM_SLOTS*ADDR_BYTES*8-1:0] slots_flat
);
   localparam int TOTAL  = NUM_SLOTS * ADDR_BYTES;
   localparam int NPAGES = (TOTAL + WIN_BYTES - 1) / WIN_BYTES;
   localparam int IDX_W  = $clog2(TOTAL);
   localparam int LIN_W  = PAGE_W + OFF_W;

   if (2 * WIN_BYTES > (1 << OFF_W)) begin : g_bad_off
      $error("offset field too narrow for the window");
   end
   if (BASE_PAGE + NPAGES > (1 << PAGE_W)) begin : g_bad_page
      $error("page range exceeds page field");
   end

   logic [7:0]        mem [TOTAL];
   logic [PAGE_W-1:0] page_rel;
   logic [LIN_W-1:0]  lin;
   logic              in_pages, off_ok, hit;
   logic [IDX_W-1:0]  idx;

   always_comb begin
      page_rel = cfg_page - PAGE_W'(BASE_PAGE);
      in_pages = (cfg_page >= PAGE_W'(BASE_PAGE)) && (page_rel < PAGE_W'(NPAGES));
      off_ok   = ({1'b0, cfg_off} >= (OFF_W+1)'(WIN_BYTES)) &&
                 ({1'b0, cfg_off} <  (OFF_W+1)'(2 * WIN_BYTES));
      lin      = LIN_W'(page_rel) * LIN_W'(WIN_BYTES) +
                 LIN_W'(cfg_off - OFF_W'(WIN_BYTES));
      hit      = in_pages && off_ok && (lin < LIN_W'(TOTAL));
      idx      = lin[IDX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
      end else if (cfg_we && hit) begin
         mem[idx] <= cfg_wdata;
      end
   end

   assign cfg_rdata = hit ? mem[idx] : 8'h00;

   for (genvar i = 0; i < TOTAL; i++) begin : g_flat
      assign slots_flat[i*8 +: 8] = mem[i];
   end
endmodule

// File: rtl/rxaf_match.sv
module rxaf_match #(
   parameter int NUM_SLOTS = 10,
   parameter int ADDR_W    = 48
) (
   input  logic [NUM_SLOTS*ADDR_W-1:0] slots_flat,
   input  logic [ADDR_W-1:0]           dst_addr,
   input  logic                        ia_en,
   output logic                        any_match
);
   logic [NUM_SLOTS-1:0] hits;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic eq;
      assign eq = (slots_flat[s*ADDR_W +: ADDR_W] == dst_addr);
      if (s == 0) begin : g_fixed
         assign hits[s] = eq;
      end else begin : g_gated
         assign hits[s] = eq & ia_en;
      end
   end

   assign any_match = |hits;
endmodule

// File: rtl/rxaf_policy.sv
module rxaf_policy
   import rxaf_pkg::*;
#(
   parameter int ADDR_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dst_valid,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic [MODE_W-1:0] mode_bits,
   input  logic              hash_hit,
   input  logic              any_match,
   output logic              res_valid,
   output rxaf_verdict_t     verdict
);
   rxaf_verdict_t nxt;
   logic          is_mc, is_bc;

   always_comb begin
      is_mc      = dst_addr[0];
      is_bc      = &dst_addr;
      nxt.match  = any_match;
      nxt.bcast  = is_bc;
      nxt.phys   = ~is_mc;
      nxt.accept = any_match
                 | (is_bc & ~mode_bits[MODE_BC_REJ])
                 | (is_mc & ~is_bc & (mode_bits[MODE_ALLMC] | hash_hit))
                 | (~is_mc & mode_bits[MODE_PROMISC]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         verdict   <= '0;
      end else begin
         res_valid <= dst_valid;
         if (dst_valid) verdict <= nxt;
      end
   end
endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter
   import rxaf_pkg::*;
#(
   parameter int NUM_SLOTS  = 10,
   parameter int ADDR_BYTES = 6,
   parameter int WIN_BYTES  = 8,
   parameter int PAGE_W     = 8,
   parameter int OFF_W      = 4,
   parameter int BASE_PAGE  = 'h50
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [PAGE_W-1:0]        cfg_page,
   input  logic [OFF_W-1:0]         cfg_off,
   input  logic [7:0]               cfg_wdata,
   output logic [7:0]               cfg_rdata,
   input  logic                     dst_valid,
   input  logic [ADDR_BYTES*8-1:0]  dst_addr,
   input  logic [MODE_W-1:0]        mode_bits,
   input  logic                     hash_hit,
   output logic                     res_valid,
   output logic                     res_accept,
   output logic                     res_phys,
   output logic                     res_bcast,
   output logic                     res_match
);
   localparam int ADDR_W = ADDR_BYTES * 8;

   logic [NUM_SLOTS*ADDR_W-1:0] slots_flat;
   logic                        any_match;
   rxaf_verdict_t               verdict;

   rxaf_store #(
      .NUM_SLOTS(NUM_SLOTS), .ADDR_BYTES(ADDR_BYTES), .WIN_BYTES(WIN_BYTES),
      .PAGE_W(PAGE_W), .OFF_W(OFF_W), .BASE_PAGE(BASE_PAGE)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_page(cfg_page),
      .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .slots_flat(slots_flat)
   );

   rxaf_match #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_match (
      .slots_flat(slots_flat), .dst_addr(dst_addr),
      .ia_en(mode_bits[MODE_IA_EN]), .any_match(any_match)
   );

   rxaf_policy #(.ADDR_W(ADDR_W)) u_policy (
      .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .dst_addr(dst_addr),
      .mode_bits(mode_bits), .hash_hit(hash_hit), .any_match(any_match),
      .res_valid(res_valid), .verdict(verdict)
   );

   assign res_accept = verdict.accept;
   assign res_phys   = verdict.phys;
   assign res_bcast  = verdict.bcast;
   assign res_match  = verdict.match;
endmodule

// File: rtl/rxaf_filter_chk.sv
module rxaf_filter_chk #(
   parameter int NUM_SLOTS  = 10,
   parameter int ADDR_BYTES = 6,
   parameter int WIN_BYTES  = 8,
   parameter int PAGE_W     = 8,
   parameter int OFF_W      = 4,
   parameter int BASE_PAGE  = 'h50
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_we,
   input logic [PAGE_W-1:0]       cfg_page,
   input logic [OFF_W-1:0]        cfg_off,
   input logic [7:0]              cfg_wdata,
   input logic [7:0]              cfg_rdata,
   input logic                    dst_valid,
   input logic [ADDR_BYTES*8-1:0] dst_addr,
   input logic [3:0]              mode_bits,
   input logic                    hash_hit,
   input logic                    res_valid,
   input logic                    res_accept,
   input logic                    res_phys,
   input logic                    res_bcast,
   input logic                    res_match
);
   localparam int TOTAL = NUM_SLOTS * ADDR_BYTES;
   logic win;

   always_comb begin
      int p, o;
      p   = int'(cfg_page) - BASE_PAGE;
      o   = int'(cfg_off) - WIN_BYTES;
      win = (p >= 0) && (o >= 0) && (o < WIN_BYTES) && (p * WIN_BYTES + o < TOTAL);
   end

   // R1
   wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && win) |=> (!$stable(cfg_page) || !$stable(cfg_off) || cfg_rdata == $past(cfg_wdata)));
   // R2
   oow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win |-> cfg_rdata == 8'h00);
   // R3
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid |=> res_valid);
   // R3
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dst_valid |=> !res_valid);
   // R5
   bcast_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && &dst_addr) |=> (res_bcast && !res_phys));
   // R5
   phys_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && !dst_addr[0]) |=> (res_phys && !res_bcast));
   // R6
   mc_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && dst_addr[0] && !(&dst_addr) && hash_hit) |=> res_accept);
   // R7
   bcast_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && &dst_addr && mode_bits[3]) |=> (res_accept == res_match));
   // R8
   promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && !dst_addr[0] && mode_bits[2]) |=> res_accept);
   // R9
   match_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_match) |-> res_accept);
endmodule

bind rxaddr_filter rxaf_filter_chk #(
   .NUM_SLOTS(NUM_SLOTS), .ADDR_BYTES(ADDR_BYTES), .WIN_BYTES(WIN_BYTES),
   .PAGE_W(PAGE_W), .OFF_W(OFF_W), .BASE_PAGE(BASE_PAGE)
) u_chk (.*);

// File: tb/rxaddr_filter_test.sv
module rxaddr_filter_test;
   localparam int NSLOT = 10;
   localparam int NB    = 6;
   localparam int TOTAL = 60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_page = '0;
   logic [3:0]  cfg_off = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        dst_valid = 1'b0;
   logic [47:0] dst_addr = '0;
   logic [3:0]  mode_bits = '0;
   logic        hash_hit = 1'b0;
   logic        res_valid, res_accept, res_phys, res_bcast, res_match;

   always #10 clk = ~clk;

   rxaddr_filter uut (.*);

   typedef struct {
      logic  acc, phys, bc, mt;
      int    due;
      string req;
   } exp_t;

   exp_t       q[$];
   logic [7:0] model [TOTAL];
   int         errs = 0, checks = 0, cyc = 0;
   bit         done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            chk({e.req, " R3 valid"}, 48'(res_valid), 48'd1);
            chk({e.req, " accept"}, 48'(res_accept), 48'(e.acc));
            chk({e.req, " R5 phys"}, 48'(res_phys), 48'(e.phys));
            chk({e.req, " R5 bcast"}, 48'(res_bcast), 48'(e.bc));
            chk({e.req, " R4 match"}, 48'(res_match), 48'(e.mt));
         end else if (res_valid) begin
            chk("R3 unexpected res_valid", 48'(res_valid), 48'd0);
         end
      end
   end

   function automatic exp_t model_eval(logic [47:0] a, logic [3:0] m, logic h, string req);
      exp_t e;
      logic mc, bc, mt;
      mt = 1'b0;
      for (int s = 0; s < NSLOT; s++) begin
         if (s == 0 || m[0]) begin
            logic eq;
            eq = 1'b1;
            for (int k = 0; k < NB; k++)
               if (model[s*NB+k] != a[k*8 +: 8]) eq = 1'b0;
            if (eq) mt = 1'b1;
         end
      end
      mc = a[0];
      bc = &a;
      e.mt   = mt;
      e.bc   = bc;
      e.phys = ~mc;
      e.acc  = mt | (bc & ~m[3]) | (mc & ~bc & (m[1] | h)) | (~mc & m[2]);
      e.due  = 0;
      e.req  = req;
      return e;
   endfunction

   task automatic send(logic [47:0] a, logic [3:0] m, logic h, string req);
      exp_t e;
      @(negedge clk);
      dst_addr  = a;
      mode_bits = m;
      hash_hit  = h;
      dst_valid = 1'b1;
      e = model_eval(a, m, h, req);
      e.due = cyc + 1;
      q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      dst_valid = 1'b0;
   endtask

   task automatic wr(logic [7:0] p, logic [3:0] o, logic [7:0] d);
      int li;
      @(negedge clk);
      cfg_page = p; cfg_off = o; cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      li = (int'(p) - 'h50) * 8 + (int'(o) - 8);
      if (p >= 8'h50 && p <= 8'h57 && o >= 4'h8 && li < TOTAL) model[li] = d;
   endtask

   task automatic wr_slot(int s, logic [47:0] a);
      for (int k = 0; k < NB; k++) begin
         int li;
         li = s * NB + k;
         wr(8'(8'h50 + li / 8), 4'(8 + li % 8), a[k*8 +: 8]);
      end
   endtask

   task automatic rd_chk(logic [7:0] p, logic [3:0] o, logic [7:0] exp, string req);
      @(negedge clk);
      cfg_page = p; cfg_off = o;
      #1;
      chk(req, 48'(cfg_rdata), 48'(exp));
   endtask

   localparam logic [47:0] A0 = 48'h554433221102;
   localparam logic [47:0] A1 = 48'hBBAA99887766;
   localparam logic [47:0] A9 = 48'h0F0E0D0C0B0A;
   localparam logic [47:0] PX = 48'h123456789A00;
   localparam logic [47:0] MX = 48'h0000005E0001;
   localparam logic [47:0] BC = 48'hFFFFFFFFFFFF;

   initial begin
      for (int i = 0; i < TOTAL; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk("R10 res_valid in reset", 48'(res_valid), 48'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 res_valid after reset", 48'(res_valid), 48'd0);
      rd_chk(8'h50, 4'h8, 8'h00, "R10 slot0 byte0 reset");
      rd_chk(8'h57, 4'hB, 8'h00, "R10 slot9 byte5 reset");

      // R1 programming, slot1 and slot9 straddle pages
      wr_slot(0, A0);
      wr_slot(1, A1);
      wr_slot(9, A9);
      rd_chk(8'h50, 4'hE, 8'h66, "R1 slot1 byte0 page50");
      rd_chk(8'h51, 4'h8, 8'h88, "R1 slot1 byte2 page51");
      rd_chk(8'h57, 4'hB, 8'h0F, "R1 slot9 last byte");

      // R2 writes outside the window
      wr(8'h57, 4'hC, 8'hA5);
      wr(8'h4F, 4'h8, 8'hA5);
      wr(8'h50, 4'h3, 8'hA5);
      wr(8'h58, 4'h8, 8'hA5);
      rd_chk(8'h57, 4'hC, 8'h00, "R2 read past end");
      rd_chk(8'h4F, 4'hF, 8'h00, "R2 read page below");
      rd_chk(8'h50, 4'h3, 8'h00, "R2 read low offset");
      for (int i = 0; i < TOTAL; i++)
         rd_chk(8'(8'h50 + i / 8), 4'(8 + i % 8), model[i], "R2 store intact");

      // R4 / R9 matching
      send(A0, 4'h0, 1'b0, "R4 R9 slot0 mode off");
      send(A1, 4'h0, 1'b0, "R4 slot1 disabled");
      send(A1, 4'h1, 1'b0, "R4 R9 slot1 enabled");
      send(A9, 4'h1, 1'b0, "R1 R4 slot9 enabled");
      idle();
      // R8 promiscuous
      send(PX, 4'h0, 1'b0, "R8 physical rejected");
      send(PX, 4'h4, 1'b0, "R8 physical promisc");
      send(MX, 4'h4, 1'b0, "R8 promisc ignores multicast");
      idle();
      // R6 multicast
      send(MX, 4'h0, 1'b1, "R6 hash hit");
      send(MX, 4'h2, 1'b0, "R6 all multicast");
      send(MX, 4'h1, 1'b0, "R5 R6 multicast rejected");
      idle();
      // R7 broadcast
      send(BC, 4'h0, 1'b0, "R7 broadcast accepted");
      send(BC, 4'h8, 1'b0, "R7 broadcast reject");
      send(BC, 4'hA, 1'b1, "R7 reject beats all-multicast");
      idle();
      repeat (4) @(negedge clk);
      chk("R3 queue drained", 48'(q.size()), 48'd0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1;
         errs++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule